// File: doc/BRIEF.md
# Eight-Pin Bidirectional GPIO Port Registers

This block is the register side of an eight-pin general-purpose I/O port. A processor reaches it through a small memory-mapped bus with a 16-bit address, separate write and read strobes, and 8-bit write and read data. Two control registers set the port's behaviour. The direction register chooses, pin by pin, whether a pin drives or listens. The output register holds the levels that the driving pins put out. A third, read-only location returns the levels present on the pins after they pass through a synchronizer.

The block does not contain the pads. It drives a per-pin output enable and output value to external tri-state pad logic, and it receives the per-pin input levels from that logic. Two reset sources act in different ways. A power-on reset clears the control registers. A manual reset leaves them alone and restarts only the bus side. Two standby indications also act in different ways. Hardware standby holds the control registers at zero. Software standby freezes them at their current values.

Top module: `gpio_port`

## Requirements
- R1: A bus write to address 0xFEB0 loads the direction register, and `pin_oe[i]` equals its bit i from the clock edge of the write onward (1 = pin drives, 0 = pin is an input with `pin_oe[i]` low). A read of 0xFEB0 returns no defined content.
- R2: A bus write to address 0xFF60 loads the output register, `pin_out[i]` equals its bit i from the clock edge of the write onward, and a read of 0xFF60 returns the stored value.
- R3: While `por_rst` or `hw_stby` is high at a rising clock edge, both the direction and output registers become 0x00, and writes in those cycles have no effect.
- R4: `man_rst` leaves the direction and output registers unchanged. Writes made while it is high are ignored, and it clears `bus_rdata` to 0x00.
- R5: While `sw_stby` is high, the direction and output registers keep their contents and bus writes to them are ignored.
- R6: A read of address 0xFF50 returns `pin_in` as sampled through a two-flop synchronizer. A level held stable for two clock edges before the read's edge is returned exactly.
- R7: Writes to 0xFF50 and accesses to any address other than the three above cause no state change in `pin_oe` or `pin_out`.
- R8: `bus_rdata` is registered. It shows the addressed value one clock after the edge that samples `bus_re`, and it is 0x00 after any edge where `bus_re` was low or the address was unmapped.
- R9: When a write and a read of 0xFF60 fall in the same cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, active high, synchronous |
| man_rst | input | 1 | Manual reset, active high, synchronous |
| hw_stby | input | 1 | Hardware standby indication, active high |
| sw_stby | input | 1 | Software standby indication, active high |
| bus_addr | input | 16 | Low 16 bits of the bus address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Input levels from the pads |
| pin_oe | output | 8 | Per-pin output enable to the pads |
| pin_out | output | 8 | Per-pin output value to the pads |

## Verification
The case that is hardest to reach from the ports is a bus write arriving while one of the freezing or clearing conditions is active. This happens when a manual reset or software standby overlaps a write, or when hardware standby overlaps one. From outside, each of these looks like an ordinary write unless the register contents are probed afterwards. The stimulus therefore holds `man_rst`, `sw_stby` and `hw_stby` over stretches of random write traffic. Directed sequences put a write and a read of the output register in the same cycle, and they change `pin_in` two cycles ahead of a pin-state read, so the synchronizer latency can be observed exactly.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_OUT  = 2'd2,
    SEL_PIN  = 2'd3
  } gpio_sel_t;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] DIR_ADDR = 16'hFEB0,
  parameter logic [15:0] OUT_ADDR = 16'hFF60,
  parameter logic [15:0] PIN_ADDR = 16'hFF50
) (
  input  logic [ADDR_W-1:0] addr_i,
  output gpio_pkg::gpio_sel_t sel_o
);
  import gpio_pkg::*;

  always_comb begin
    if (addr_i == ADDR_W'(DIR_ADDR))      sel_o = SEL_DIR;
    else if (addr_i == ADDR_W'(OUT_ADDR)) sel_o = SEL_OUT;
    else if (addr_i == ADDR_W'(PIN_ADDR)) sel_o = SEL_PIN;
    else                                  sel_o = SEL_NONE;
  end
endmodule

// File: rtl/gpio_ctl_reg.sv
module gpio_ctl_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_i,
  input  logic             man_rst_i,
  input  logic             sw_stby_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] q_o
);
  logic wr_ok;
  assign wr_ok = wr_i && !man_rst_i && !sw_stby_i;

  always_ff @(posedge clk) begin
    if (clr_i)      q_o <= '0;
    else if (wr_ok) q_o <= wdata_i;
  end

  // R3: clearing condition empties the register on the next edge
  p_clear_r3: assert property (@(posedge clk) clr_i |=> (q_o == '0));

  // R4: manual reset freezes the register
  p_hold_man_r4: assert property (@(posedge clk) disable iff (clr_i)
    man_rst_i |=> $stable(q_o));

  // R5: software standby freezes the register
  p_hold_sw_r5: assert property (@(posedge clk) disable iff (clr_i)
    sw_stby_i |=> $stable(q_o));

  // R1/R2: an accepted write lands
  p_write_r2: assert property (@(posedge clk) disable iff (clr_i)
    (wr_i && !man_rst_i && !sw_stby_i) |=> (q_o == $past(wdata_i)));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst_i) stage_q[0] <= '0;
        else       stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst_i) stage_q[s] <= '0;
        else       stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int          NPINS    = 8,
  parameter int          ADDR_W   = 16,
  parameter int          SYNC_N   = 2,
  parameter logic [15:0] DIR_ADDR = 16'hFEB0,
  parameter logic [15:0] OUT_ADDR = 16'hFF60,
  parameter logic [15:0] PIN_ADDR = 16'hFF50
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              man_rst,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_out
);
  import gpio_pkg::*;

  gpio_sel_t        sel;
  logic             ctl_clr;
  logic [NPINS-1:0] dir_q, out_q, pin_sync;

  assign ctl_clr = por_rst || hw_stby;

  gpio_addr_dec #(
    .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .OUT_ADDR(OUT_ADDR), .PIN_ADDR(PIN_ADDR)
  ) u_dec (
    .addr_i(bus_addr),
    .sel_o (sel)
  );

  gpio_ctl_reg #(.WIDTH(NPINS)) u_dir (
    .clk(clk), .clr_i(ctl_clr), .man_rst_i(man_rst), .sw_stby_i(sw_stby),
    .wr_i(bus_we && (sel == SEL_DIR)), .wdata_i(bus_wdata), .q_o(dir_q)
  );

  gpio_ctl_reg #(.WIDTH(NPINS)) u_out (
    .clk(clk), .clr_i(ctl_clr), .man_rst_i(man_rst), .sw_stby_i(sw_stby),
    .wr_i(bus_we && (sel == SEL_OUT)), .wdata_i(bus_wdata), .q_o(out_q)
  );

  gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_i(por_rst), .d_i(pin_in), .q_o(pin_sync)
  );

  always_ff @(posedge clk) begin
    if (por_rst || man_rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      case (sel)
        SEL_OUT: bus_rdata <= out_q;
        SEL_PIN: bus_rdata <= pin_sync;
        default: bus_rdata <= '0;
      endcase
    end else begin
      bus_rdata <= '0;
    end
  end

  assign pin_oe  = dir_q;
  assign pin_out = out_q;

  // R8: idle read strobe leaves read data at zero
  p_rd_idle_r8: assert property (@(posedge clk) disable iff (por_rst || man_rst)
    !bus_re |=> (bus_rdata == '0));

  // R2: reading the output register without a write returns the pin value
  p_rd_out_r2: assert property (@(posedge clk) disable iff (por_rst || man_rst || hw_stby)
    (bus_re && !bus_we && bus_addr == ADDR_W'(OUT_ADDR)) |=> (bus_rdata == pin_out));

  // R7: writes outside the control registers change no pad control
  p_ign_r7: assert property (@(posedge clk) disable iff (por_rst || hw_stby)
    (bus_we && bus_addr != ADDR_W'(DIR_ADDR) && bus_addr != ADDR_W'(OUT_ADDR))
      |=> ($stable(pin_oe) && $stable(pin_out)));
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam logic [15:0] A_DIR = 16'hFEB0;
  localparam logic [15:0] A_OUT = 16'hFF60;
  localparam logic [15:0] A_PIN = 16'hFF50;

  logic        clk = 0;
  logic        por_rst, man_rst, hw_stby, sw_stby, bus_we, bus_re;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata, pin_in, pin_oe, pin_out;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_dir, m_out;

  always #2.5 clk = ~clk;

  gpio_port dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic bit accepted();
    return !man_rst && !sw_stby && !hw_stby && !por_rst;
  endfunction

  task automatic wr(logic [15:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    if (hw_stby || por_rst) begin m_dir = 0; m_out = 0; end
    else if (accepted()) begin
      if (a == A_DIR) m_dir = d;
      if (a == A_OUT) m_out = d;
    end
    cyc();
    bus_we = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] v);
    bus_addr = a; bus_re = 1;
    cyc();
    v = bus_rdata;
    bus_re = 0;
  endtask

  task automatic chk_pads(string req);
    chk({req, " oe"}, pin_oe, m_dir);
    chk({req, " out"}, pin_out, m_out);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    por_rst = 1; man_rst = 0; hw_stby = 0; sw_stby = 0;
    bus_we = 0; bus_re = 0; bus_addr = 0; bus_wdata = 0; pin_in = 8'h00;
    m_dir = 0; m_out = 0;
    @(negedge clk); cyc(); cyc();
    por_rst = 0; cyc();
    chk_pads("R3 reset");
    chk("R8 reset rdata", bus_rdata, 8'h00);

    wr(A_DIR, 8'hA5); chk_pads("R1 dir write");
    wr(A_OUT, 8'h3C); chk_pads("R2 out write");
    rd(A_OUT, v);     chk("R2 out readback", v, 8'h3C);
    cyc();            chk("R8 idle rdata", bus_rdata, 8'h00);

    // R9 same-cycle write and read
    bus_addr = A_OUT; bus_wdata = 8'hC3; bus_we = 1; bus_re = 1; m_out = 8'hC3;
    cyc(); bus_we = 0; bus_re = 0;
    chk("R9 read old value", bus_rdata, 8'h3C);
    chk_pads("R9 write lands");

    // R6 pin synchronizer
    pin_in = 8'h5A; cyc(); cyc();
    rd(A_PIN, v); chk("R6 pin read", v, 8'h5A);
    pin_in = 8'hE1; cyc();
    rd(A_PIN, v); chk("R6 one edge is too early", v, 8'h5A);

    // R7 ignored writes
    wr(A_PIN, 8'hFF); chk_pads("R7 pin-state write");
    wr(16'h1234, 8'h00); chk_pads("R7 unmapped write");
    rd(16'h1234, v); chk("R8 unmapped read", v, 8'h00);

    // R4 manual reset
    man_rst = 1; wr(A_DIR, 8'h00); wr(A_OUT, 8'h00);
    chk_pads("R4 manual reset hold");
    chk("R4 rdata cleared", bus_rdata, 8'h00);
    man_rst = 0; cyc();

    // R5 software standby
    sw_stby = 1; wr(A_DIR, 8'h11); wr(A_OUT, 8'h22);
    chk_pads("R5 sw standby hold");
    sw_stby = 0; cyc();

    // R3 hardware standby
    hw_stby = 1; cyc(); m_dir = 0; m_out = 0;
    chk_pads("R3 hw standby clear");
    wr(A_DIR, 8'hFF); chk_pads("R3 hw standby write blocked");
    hw_stby = 0; cyc();

    // random traffic
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      man_rst = ($urandom_range(0, 7) == 0);
      sw_stby = ($urandom_range(0, 7) == 0);
      hw_stby = ($urandom_range(0, 15) == 0);
      case (op)
        0, 1: wr(A_DIR, 8'($urandom));
        2, 3: wr(A_OUT, 8'($urandom));
        4:    wr(A_PIN, 8'($urandom));
        5:    wr(16'($urandom), 8'($urandom));
        6: begin
          logic ok;
          ok = !man_rst && !hw_stby;
          if (hw_stby) begin m_dir = 0; m_out = 0; end
          rd(A_OUT, v);
          if (ok) chk("R2 random readback", v, m_out);
        end
        7: begin
          logic [7:0] p;
          p = 8'($urandom); pin_in = p;
          if (hw_stby) begin m_dir = 0; m_out = 0; end
          cyc(); cyc();
          man_rst = 0;
          rd(A_PIN, v); chk("R6 random pin read", v, p);
        end
        default: begin
          if (hw_stby) begin m_dir = 0; m_out = 0; end
          cyc();
        end
      endcase
      if (hw_stby) begin m_dir = 0; m_out = 0; end
      chk_pads("R1 R2 R4 R5 random pads");
      man_rst = 0; sw_stby = 0; hw_stby = 0;
    end

    por_rst = 1; cyc(); m_dir = 0; m_out = 0; por_rst = 0;
    chk_pads("R3 late power-on reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule